// File: doc/BRIEF.md
# Window Limit Status Latch

This block watches the results of a multi-channel measurement front end, such as supply voltages and fan tachometer counts. Each converted result arrives with its channel index and a one-cycle valid strobe. The block compares the result against that channel's programmable upper and lower bound. A result outside the window sets a status bit for the channel. The bit stays set across later conversions until the host reads it.

The host has two views of the status word. The clearing view is a read strobe: the word is captured onto a read-data port and the bits are cleared. The mirror view is a continuously driven port, and observing it never changes the status. An interrupt request is raised while any status bit is set, and it feeds a downstream interrupt combiner. A channel that is still out of window on its next conversion sets its bit again and so raises a new request.

Top module: `window_status_latch`

## Requirements
- R1: After reset is released, the mirror status, the read data and the interrupt request are all zero.
- R2: A valid conversion whose value is strictly greater than the channel's high limit sets status bit `conv_chan` in the mirror view one cycle after the strobe.
- R3: A valid conversion whose value is strictly less than the channel's low limit sets status bit `conv_chan` one cycle after the strobe.
- R4: A value equal to either limit, or between them, leaves the status word unchanged.
- R5: A set bit stays set on later conversions that are back inside the window, as long as no clearing read occurs.
- R6: A clearing read strobe captures the status word as it stood before that clock edge onto `rd_data`, which is valid from the next cycle and holds until the next read. All bits that were read are cleared at the same edge.
- R7: If a set event and a clearing read fall on the same clock edge, the bit being set remains set afterwards.
- R8: The mirror view is not cleared by time passing or by observation; only a clearing read clears bits.
- R9: `irq_req` is high exactly when at least one status bit is set, and it drops in the cycle after a clearing read that coincides with no set event.
- R10: After a clearing read, a channel still out of window on its next conversion sets its bit again and raises `irq_req` again.
- R11: When `conv_valid` is low, the channel index and value inputs have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_valid | input | 1 | One-cycle strobe qualifying a conversion result |
| conv_chan | input | 3 | Channel index of the result; bit position in the status word |
| conv_value | input | 8 | Converted value, unsigned |
| hi_limit | input | 64 | Per-channel high limits; channel n at bits [8n+7:8n] |
| lo_limit | input | 64 | Per-channel low limits; channel n at bits [8n+7:8n] |
| rd_clr | input | 1 | Clearing read strobe |
| rd_data | output | 8 | Status word captured by the last clearing read |
| status_mirror | output | 8 | Live status word; reading it has no side effect |
| irq_req | output | 1 | Interrupt request, high while any status bit is set |

## Verification
Every result is due exactly one clock edge after its stimulus. A conversion or a read strobe presented before an edge shows up in `status_mirror`, `rd_data` and `irq_req` right after that edge. Reset release takes two further edges through the synchronizer. The bench drives each stimulus on the falling edge, waits for one rising edge, updates its arithmetic expectation, and compares all three outputs at the next falling edge. So every comparison falls in the first cycle in which the result is due. A sweep over every channel and every 8-bit value, with clearing reads on every third cycle, covers the limit boundaries and same-edge set and clear collisions.

// File: rtl/wls_pkg.sv
`timescale 1ns/1ps
package wls_pkg;
  localparam int unsigned WLS_NUM_CH = 8;
  localparam int unsigned WLS_VAL_W  = 8;
endpackage

// File: rtl/wls_rst_sync.sv
`timescale 1ns/1ps
module wls_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wls_window_cmp.sv
`timescale 1ns/1ps
module wls_window_cmp #(
  parameter int unsigned NUM_CH = wls_pkg::WLS_NUM_CH,
  parameter int unsigned VAL_W  = wls_pkg::WLS_VAL_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n_i,
  input  logic                    conv_valid,
  input  logic [CH_W-1:0]         conv_chan,
  input  logic [VAL_W-1:0]        conv_value,
  input  logic [NUM_CH*VAL_W-1:0] hi_limit,
  input  logic [NUM_CH*VAL_W-1:0] lo_limit,
  output logic [NUM_CH-1:0]       set_vec
);
  // One window check per channel; only the addressed one may fire.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [VAL_W-1:0] hi_g;
    logic [VAL_W-1:0] lo_g;
    logic             sel_g;
    logic             above_g;
    logic             below_g;

    assign hi_g    = hi_limit[g*VAL_W +: VAL_W];
    assign lo_g    = lo_limit[g*VAL_W +: VAL_W];
    assign sel_g   = conv_valid && (conv_chan == CH_W'(g));
    assign above_g = conv_value > hi_g;
    assign below_g = conv_value < lo_g;
    assign set_vec[g] = sel_g && (above_g || below_g);
  end

  // R11: no conversion strobe, no set event
  p_idle_no_set_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    !conv_valid |-> (set_vec == '0));

  // R2/R3: at most one channel set per conversion
  p_single_set_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(set_vec));
endmodule

// File: rtl/wls_status_bank.sv
`timescale 1ns/1ps
module wls_status_bank #(
  parameter int unsigned NUM_CH = wls_pkg::WLS_NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              rd_clr,
  output logic [NUM_CH-1:0] status_q,
  output logic [NUM_CH-1:0] rd_data_q,
  output logic              irq_req
);
  logic [NUM_CH-1:0] status_d;
  logic [NUM_CH-1:0] rd_data_d;
  logic [NUM_CH-1:0] keep_mask;
  logic              status_en;
  logic              rd_en;

  // Next state: a read drops what was held, a set always lands on top.
  always_comb begin
    keep_mask = rd_clr ? '0 : '1;
    status_en = rd_clr || (set_vec != '0);
    status_d  = (status_q & keep_mask) | set_vec;
    rd_en     = rd_clr;
    rd_data_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign irq_req = |status_q;

  // R5/R8: without a read no bit falls
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: a read empties all bits not set at that edge
  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_clr |=> ((status_q & ~$past(set_vec)) == '0));

  // R6: read data is the pre-edge word
  p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_clr |=> (rd_data_q == $past(status_q)));

  // R7: a set lands even against a read
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R9: request falls after a clean read
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_clr && (set_vec == '0)) |=> !irq_req);
endmodule

// File: rtl/window_status_latch.sv
`timescale 1ns/1ps
module window_status_latch #(
  parameter int unsigned NUM_CH = wls_pkg::WLS_NUM_CH,
  parameter int unsigned VAL_W  = wls_pkg::WLS_VAL_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    conv_valid,
  input  logic [CH_W-1:0]         conv_chan,
  input  logic [VAL_W-1:0]        conv_value,
  input  logic [NUM_CH*VAL_W-1:0] hi_limit,
  input  logic [NUM_CH*VAL_W-1:0] lo_limit,
  input  logic                    rd_clr,
  output logic [NUM_CH-1:0]       rd_data,
  output logic [NUM_CH-1:0]       status_mirror,
  output logic                    irq_req
);
  logic              rst_n_i;
  logic [NUM_CH-1:0] set_vec;

  wls_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wls_window_cmp #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_cmp (
    .clk        (clk),
    .rst_n_i    (rst_n_i),
    .conv_valid (conv_valid),
    .conv_chan  (conv_chan),
    .conv_value (conv_value),
    .hi_limit   (hi_limit),
    .lo_limit   (lo_limit),
    .set_vec    (set_vec)
  );

  wls_status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n_i   (rst_n_i),
    .set_vec   (set_vec),
    .rd_clr    (rd_clr),
    .status_q  (status_mirror),
    .rd_data_q (rd_data),
    .irq_req   (irq_req)
  );

  // R10: an out-of-window conversion leaves the request raised
  p_reraise_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (set_vec != '0) |=> irq_req);

  // R1: outputs quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_i |-> (status_mirror == '0 && rd_data == '0 && !irq_req));
endmodule

// File: tb/tb_window_status_latch.sv
`timescale 1ns/1ps
module tb_window_status_latch;
  localparam int NCH = 8;
  localparam int W   = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             conv_valid;
  logic [2:0]       conv_chan;
  logic [W-1:0]     conv_value;
  logic [NCH*W-1:0] hi_limit;
  logic [NCH*W-1:0] lo_limit;
  logic             rd_clr;
  logic [NCH-1:0]   rd_data;
  logic [NCH-1:0]   status_mirror;
  logic             irq_req;

  int n_vec  = 0;
  int n_fail = 0;
  logic [NCH-1:0] exp_status = '0;
  logic [NCH-1:0] exp_rd     = '0;

  always #2 clk = ~clk;

  window_status_latch dut (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
    .conv_value(conv_value), .hi_limit(hi_limit), .lo_limit(lo_limit),
    .rd_clr(rd_clr), .rd_data(rd_data), .status_mirror(status_mirror),
    .irq_req(irq_req)
  );

  function automatic int lo_of(int ch); return 30 + ch * 9;   endfunction
  function automatic int hi_of(int ch); return 150 + ch * 11; endfunction

  task automatic check(string tag);
    n_vec++;
    if (status_mirror !== exp_status || rd_data !== exp_rd ||
        irq_req !== (exp_status != '0)) begin
      n_fail++;
      $display("FAIL %s: status=%02h exp=%02h rd=%02h exp=%02h irq=%0b exp=%0b",
               tag, status_mirror, exp_status, rd_data, exp_rd, irq_req,
               (exp_status != '0));
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, compare.
  task automatic step(input logic v, input int ch, input int val,
                      input logic rd, input string tag);
    logic [NCH-1:0] s;
    conv_valid = v; conv_chan = 3'(ch); conv_value = 8'(val); rd_clr = rd;
    @(posedge clk);
    s = '0;
    if (v && (val > hi_of(ch) || val < lo_of(ch))) s[ch] = 1'b1;
    if (rd) exp_rd = exp_status;
    exp_status = (rd ? '0 : exp_status) | s;
    @(negedge clk);
    conv_valid = 1'b0; rd_clr = 1'b0;
    check(tag);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      hi_limit[c*W +: W] = 8'(hi_of(c));
      lo_limit[c*W +: W] = 8'(lo_of(c));
    end
    rst_n = 1'b0; conv_valid = 1'b0; conv_chan = '0; conv_value = '0; rd_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state");

    step(1, 2, hi_of(2) + 1, 0, "R2 above high");
    step(1, 5, lo_of(5) - 1, 0, "R3 below low");
    step(1, 0, hi_of(0), 0, "R4 equal high");
    step(1, 0, lo_of(0), 0, "R4 equal low");
    step(1, 6, 100, 0, "R4 inside");
    step(1, 2, 100, 0, "R5 back inside keeps bit");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, "R8 mirror holds");
    step(0, 0, 255, 0, "R11 strobe low ignored");
    step(0, 0, 0, 1, "R6 clearing read");
    step(0, 0, 0, 0, "R9 irq dropped");
    step(1, 3, 255, 0, "R10 set before read");
    step(1, 3, 255, 1, "R7 set wins over read");
    step(0, 0, 0, 1, "R6 read after collision");
    step(1, 3, 255, 0, "R10 still out sets again");
    step(0, 0, 0, 1, "R9 clear again");

    for (int ch = 0; ch < NCH; ch++)
      for (int v = 0; v < 256; v++)
        step(1, ch, v, ((v % 3) == 0), "R2 R3 R4 R7 sweep");
    step(0, 0, 0, 1, "R6 final read");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule